// File: doc/BRIEF.md
# Serial Two-Wire EEPROM Target

This block is a target device on a two-wire I2C bus that fronts a 256-byte memory held in on-chip flip-flops. A controller reaches it with a device-address byte, an optional word address and then data. The block supports a single-byte write and a page write of up to 16 bytes. It also supports a read at a given address, a read at the current address and an open-ended sequential read. A word-address counter persists between transactions, so a read with no address phase continues where the last access left off.

Written bytes are collected in a page buffer. They reach the array only when the controller ends the transfer with a stop condition. A commit then starts a busy interval of a configurable number of clock cycles, and during it the block does not acknowledge its own address. Two independent inhibits block programming: a write-protect input and an input that signals the supply is below its threshold. While either is high, data bytes are still acknowledged but the array is left as it was.

The bus lines are sampled with the system clock through a synchroniser. The bus rate must stay well below the clock rate. SDA is an open-drain pull-low enable.

Top module: `i2c_eeprom`

## Requirements
- R1: After reset the SDA pull-down is off, the address counter is 0, and every memory byte reads 0xFF.
- R2: The device-address byte is bits 7..4 = 4'b1010, bits 3..1 = `dev_sel_i`, and bit 0 = direction (1 = read). On a mismatch the block gives no acknowledge and ignores the bus until the next start.
- R3: For every byte the block receives, it pulls SDA low during the ninth SCL clock: the matching device address, the word address and each data byte.
- R4: Write data goes to a 16-byte page buffer and is committed to the array at the stop. The low 4 address bits advance and wrap within the page, and the high 4 bits stay fixed. A later byte to the same slot replaces the earlier one.
- R5: A repeated start before a stop discards the buffered write data, and the array is left unchanged.
- R6: A write of a word address, then a repeated start and a read, returns the byte at that address.
- R7: A read without an address phase returns the byte at the address counter. The counter holds the last accessed address plus one, and after a write that increment wraps within the page.
- R8: A sequential read advances the full 8-bit address and wraps from 255 to 0. It ends when the controller NACKs, and the block then releases SDA.
- R9: A commit starts a busy interval of `BUSY_CYCLES` clocks. During it a matching device address gets no acknowledge.
- R10: With `wp_i` high, data bytes are acknowledged, but the stop commits nothing and starts no busy interval.
- R11: With `supply_low_i` high, the behaviour is the same as R10.
- R12: The SDA enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| wp_i | input | 1 | Write protect, high blocks programming |
| supply_low_i | input | 1 | Supply below threshold, high blocks programming |
| dev_sel_i | input | 3 | Chip-select bits compared with the device address |

## Verification
A wrong bit count or phase shows up within one byte time, as an acknowledge in the wrong clock or a missing one, or as a read byte shifted by a bit. A corrupted address counter or page wrap does not show at once. It surfaces at the next current-address or sequential read, so every write is followed by read-back across whole pages and across the 255-to-0 wrap. Faults in the busy or inhibit paths show on the first device-address byte after a stop, which is probed right away.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
    localparam logic [3:0] DEV_TYPE_ID = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_WAIT
    } phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_p;
        logic [STAGES-1:0] sda_p;
        logic              scl_l;
        logic              sda_l;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d       = q;
        d.scl_p = {q.scl_p[STAGES-2:0], scl_i};
        d.sda_p = {q.sda_p[STAGES-2:0], sda_i};
        d.scl_l = q.scl_p[STAGES-1];
        d.sda_l = q.sda_p[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl_p: '1, sda_p: '1, scl_l: 1'b1, sda_l: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign scl_s     = q.scl_p[STAGES-1];
    assign sda_s     = q.sda_p[STAGES-1];
    assign scl_rise  = scl_s & ~q.scl_l;
    assign scl_fall  = ~scl_s & q.scl_l;
    assign start_det = scl_s & q.scl_l & q.sda_l & ~sda_s;
    assign stop_det  = scl_s & q.scl_l & ~q.sda_l & sda_s;
endmodule

// File: rtl/i2c_ee_array.sv
module i2c_ee_array #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] wr_page,
    input  logic [PAGE_BYTES-1:0]   wr_mask,
    input  logic [PAGE_BYTES*8-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [7:0]              rd_data
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int PG_W   = ADDR_W - PAGE_W;

    logic [DEPTH*8-1:0] mem_flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        localparam int SLOT = g % PAGE_BYTES;
        localparam int PG   = g / PAGE_BYTES;
        logic [7:0] byte_d, byte_q;

        always_comb begin
            byte_d = byte_q;
            if (wr_en && (wr_page == PG_W'(PG)) && wr_mask[SLOT]) begin
                byte_d = wr_data[SLOT*8 +: 8];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= 8'hFF;
            end else begin
                byte_q <= byte_d;
            end
        end

        assign mem_flat[g*8 +: 8] = byte_q;
    end

    assign rd_data = mem_flat[{rd_addr, 3'b000} +: 8];
endmodule

// File: rtl/i2c_ee_ctrl.sv
module i2c_ee_ctrl
    import i2c_ee_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PAGE_BYTES  = 16,
    parameter int BUSY_CYCLES = 1000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sda_s,
    input  logic                    scl_rise,
    input  logic                    scl_fall,
    input  logic                    start_det,
    input  logic                    stop_det,
    input  logic [2:0]              dev_sel_i,
    input  logic                    wp_i,
    input  logic                    supply_low_i,
    input  logic [7:0]              rd_data,
    output logic                    sda_oe_o,
    output logic                    wr_en,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] wr_page,
    output logic [PAGE_BYTES-1:0]   wr_mask,
    output logic [PAGE_BYTES*8-1:0] wr_data,
    output logic [ADDR_W-1:0]       rd_addr,
    output phase_e                  phase_o,
    output logic [$clog2(BUSY_CYCLES+1)-1:0] busy_o
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int BUSY_W = $clog2(BUSY_CYCLES+1);

    typedef struct packed {
        phase_e                  phase;
        logic [3:0]              bitn;
        logic [7:0]              sh;
        logic                    ackslot;
        logic                    rw;
        logic                    nack;
        logic                    oe;
        logic [ADDR_W-1:0]       ptr;
        logic [PAGE_BYTES-1:0]   mask;
        logic [PAGE_BYTES*8-1:0] pbuf;
        logic [BUSY_W-1:0]       busy;
        logic                    commit;
    } ctrl_t;

    ctrl_t q, d;
    logic [PAGE_W-1:0] slot;
    logic              dev_hit;

    assign slot    = q.ptr[PAGE_W-1:0];
    assign dev_hit = (q.sh[7:4] == DEV_TYPE_ID) && (q.sh[3:1] == dev_sel_i)
                     && (q.busy == '0);

    always_comb begin
        d        = q;
        d.commit = 1'b0;
        if (q.busy != '0) begin
            d.busy = q.busy - 1'b1;
        end

        if (stop_det) begin
            if (q.phase == PH_WDATA && (|q.mask) && !wp_i && !supply_low_i) begin
                d.commit = 1'b1;
                d.busy   = BUSY_W'(BUSY_CYCLES);
            end
            d.phase   = PH_IDLE;
            d.oe      = 1'b0;
            d.ackslot = 1'b0;
        end else if (start_det) begin
            d.phase   = PH_DEV;
            d.bitn    = '0;
            d.ackslot = 1'b0;
            d.oe      = 1'b0;
            d.mask    = '0;
        end else if (scl_rise) begin
            if (q.phase == PH_DEV || q.phase == PH_ADDR || q.phase == PH_WDATA) begin
                if (!q.ackslot && q.bitn < 4'd8) begin
                    d.sh   = {q.sh[6:0], sda_s};
                    d.bitn = q.bitn + 4'd1;
                end
            end else if (q.phase == PH_RDATA && q.ackslot) begin
                d.nack = sda_s;
            end
        end else if (scl_fall) begin
            case (q.phase)
                PH_DEV, PH_ADDR, PH_WDATA: begin
                    if (!q.ackslot && q.bitn == 4'd8) begin
                        d.bitn    = '0;
                        d.ackslot = 1'b1;
                        d.oe      = 1'b1;
                        if (q.phase == PH_DEV) begin
                            if (dev_hit) begin
                                d.rw = q.sh[0];
                            end else begin
                                d.phase   = PH_WAIT;
                                d.ackslot = 1'b0;
                                d.oe      = 1'b0;
                            end
                        end else if (q.phase == PH_ADDR) begin
                            d.ptr = q.sh[ADDR_W-1:0];
                        end else begin
                            d.pbuf[{slot, 3'b000} +: 8] = q.sh;
                            d.mask[slot]                = 1'b1;
                            d.ptr = {q.ptr[ADDR_W-1:PAGE_W], PAGE_W'(slot + 1'b1)};
                        end
                    end else if (q.ackslot) begin
                        d.ackslot = 1'b0;
                        d.oe      = 1'b0;
                        d.bitn    = '0;
                        if (q.phase == PH_DEV) begin
                            if (q.rw) begin
                                d.phase = PH_RDATA;
                                d.sh    = rd_data;
                                d.oe    = ~rd_data[7];
                                d.bitn  = 4'd1;
                                d.ptr   = q.ptr + 1'b1;
                            end else begin
                                d.phase = PH_ADDR;
                            end
                        end else if (q.phase == PH_ADDR) begin
                            d.phase = PH_WDATA;
                        end
                    end
                end
                PH_RDATA: begin
                    if (q.ackslot) begin
                        d.ackslot = 1'b0;
                        if (q.nack) begin
                            d.phase = PH_WAIT;
                            d.oe    = 1'b0;
                        end else begin
                            d.sh   = rd_data;
                            d.oe   = ~rd_data[7];
                            d.bitn = 4'd1;
                            d.ptr  = q.ptr + 1'b1;
                        end
                    end else if (q.bitn < 4'd8) begin
                        d.oe   = ~q.sh[6];
                        d.sh   = {q.sh[6:0], 1'b0};
                        d.bitn = q.bitn + 4'd1;
                    end else begin
                        d.oe      = 1'b0;
                        d.ackslot = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;
    assign wr_en    = q.commit;
    assign wr_page  = q.ptr[ADDR_W-1:PAGE_W];
    assign wr_mask  = q.mask;
    assign wr_data  = q.pbuf;
    assign rd_addr  = q.ptr;
    assign phase_o  = q.phase;
    assign busy_o   = q.busy;
endmodule

// File: rtl/i2c_eeprom.sv
module i2c_eeprom
    import i2c_ee_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PAGE_BYTES  = 16,
    parameter int BUSY_CYCLES = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic       wp_i,
    input  logic       supply_low_i,
    input  logic [2:0] dev_sel_i
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int PG_W   = ADDR_W - PAGE_W;
    localparam int BUSY_W = $clog2(BUSY_CYCLES+1);

    logic                    scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic                    wr_en;
    logic [PG_W-1:0]         wr_page;
    logic [PAGE_BYTES-1:0]   wr_mask;
    logic [PAGE_BYTES*8-1:0] wr_data;
    logic [ADDR_W-1:0]       rd_addr;
    logic [7:0]              rd_data;
    phase_e                  phase;
    logic [BUSY_W-1:0]       busy;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_ee_ctrl #(
        .ADDR_W      (ADDR_W),
        .PAGE_BYTES  (PAGE_BYTES),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sda_s        (sda_s),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .dev_sel_i    (dev_sel_i),
        .wp_i         (wp_i),
        .supply_low_i (supply_low_i),
        .rd_data      (rd_data),
        .sda_oe_o     (sda_oe_o),
        .wr_en        (wr_en),
        .wr_page      (wr_page),
        .wr_mask      (wr_mask),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .phase_o      (phase),
        .busy_o       (busy)
    );

    i2c_ee_array #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_page (wr_page),
        .wr_mask (wr_mask),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/i2c_ee_checker.sv
module i2c_ee_checker
    import i2c_ee_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PAGE_BYTES  = 16,
    parameter int BUSY_CYCLES = 1000
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    scl_s,
    input logic                    sda_oe,
    input phase_e                  phase,
    input logic [$clog2(BUSY_CYCLES+1)-1:0] busy,
    input logic [ADDR_W-1:0]       ptr,
    input logic                    wr_en,
    input logic                    wp,
    input logic                    supply_low
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int BUSY_W = $clog2(BUSY_CYCLES+1);

    p_sda_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        scl_s && $past(scl_s) |-> $stable(sda_oe));

    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_IDLE |-> !sda_oe);

    p_busy_no_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_DEV && sda_oe |-> busy == '0);

    p_busy_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy == BUSY_W'(BUSY_CYCLES));

    p_commit_wp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(wp));

    p_commit_supply_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(supply_low));

    p_page_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_WDATA && $past(phase) == PH_WDATA
        |-> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));
endmodule

bind i2c_eeprom i2c_ee_checker #(
    .ADDR_W      (ADDR_W),
    .PAGE_BYTES  (PAGE_BYTES),
    .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .sda_oe     (sda_oe_o),
    .phase      (phase),
    .busy       (busy),
    .ptr        (rd_addr),
    .wr_en      (wr_en),
    .wp         (wp_i),
    .supply_low (supply_low_i)
);

// File: tb/i2c_eeprom_tb.sv
module i2c_eeprom_tb;
    localparam int Q    = 5;
    localparam int BUSY = 400;
    localparam logic [2:0] SEL = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, SEL, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic slow = 1'b0;
    logic sda_oe;
    logic sda_bus;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    int r12_viol = 0;
    logic [7:0] model [256];

    always #2 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_eeprom #(.BUSY_CYCLES(BUSY)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .sda_oe_o     (sda_oe),
        .wp_i         (wp),
        .supply_low_i (slow),
        .dev_sel_i    (SEL)
    );

    // R12 monitor: the pull-down may only move while SCL is low
    logic scl_prev = 1'b1;
    logic oe_prev  = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl_m && scl_prev && (sda_oe !== oe_prev)) r12_viol++;
        scl_prev <= scl_m;
        oe_prev  <= sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        tick(Q); sda_m = b;
        tick(Q); scl_m = 1'b1;
        tick(2*Q); scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        tick(Q); sda_m = 1'b1;
        tick(Q); scl_m = 1'b1;
        tick(Q); b = sda_bus;
        tick(Q); scl_m = 1'b0;
    endtask

    task automatic bus_start();
        tick(Q); sda_m = 1'b1;
        tick(Q); scl_m = 1'b1;
        tick(2*Q); sda_m = 1'b0;
        tick(Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); sda_m = 1'b0;
        tick(Q); scl_m = 1'b1;
        tick(Q); sda_m = 1'b1;
        tick(Q);
    endtask

    task automatic send(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv(input logic ack_it, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~ack_it);
    endtask

    task automatic read_at(input logic [7:0] a, input string req);
        logic ack;
        bus_start();
        send(DEV_W, ack); check({req, " dev ack"}, 8'(ack), 8'd1);
        send(a, ack);     check({req, " addr ack"}, 8'(ack), 8'd1);
        bus_start();
        send(DEV_R, ack); check({req, " dev-read ack"}, 8'(ack), 8'd1);
    endtask

    initial begin
        logic ack;
        logic [7:0] v;
        logic [7:0] a;
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: released after reset
        check("R1 sda released", 8'(sda_oe), 8'd0);

        // R1 R7: current-address read after reset hits address 0, erased
        bus_start();
        send(DEV_R, ack); check("R2 R3 dev ack", 8'(ack), 8'd1);
        recv(1'b0, v);    check("R1 R7 erased byte at 0", v, 8'hFF);
        bus_stop();

        // R2: wrong type identifier and wrong chip select are ignored
        bus_start();
        send({4'b1011, SEL, 1'b0}, ack); check("R2 bad type nack", 8'(ack), 8'd0);
        bus_stop();
        bus_start();
        send({4'b1010, 3'b010, 1'b0}, ack); check("R2 bad select nack", 8'(ack), 8'd0);
        check("R2 released after mismatch", 8'(sda_oe), 8'd0);
        bus_stop();

        // R4 R3: full page sweep, each page starting at a different offset
        for (int p = 0; p < 16; p++) begin
            bus_start();
            send(DEV_W, ack); check("R3 dev ack", 8'(ack), 8'd1);
            send({4'(p), 4'(p)}, ack); check("R3 addr ack", 8'(ack), 8'd1);
            for (int i = 0; i < 16; i++) begin
                a = {4'(p), 4'(p + i)};
                send(8'(a * 37 + 11), ack); check("R3 data ack", 8'(ack), 8'd1);
                model[a] = 8'(a * 37 + 11);
            end
            bus_stop();
            if (p == 0) begin
                bus_start();
                send(DEV_W, ack); check("R9 busy nack", 8'(ack), 8'd0);
                bus_stop();
            end
            tick(BUSY + 100);
        end

        // R6 R8: read all bytes from 0 and across the 255->0 wrap
        read_at(8'h00, "R6");
        for (int i = 0; i < 257; i++) begin
            recv(i != 256, v);
            check("R8 sequential data", v, model[8'(i)]);
        end
        check("R8 released after nack", 8'(sda_oe), 8'd0);
        bus_stop();

        // R7: counter is last read address (0) plus one
        bus_start();
        send(DEV_R, ack);
        recv(1'b0, v); check("R7 current read after sequential", v, model[1]);
        bus_stop();

        // R4 R7: byte write, then current read gives the next byte
        bus_start();
        send(DEV_W, ack); send(8'h35, ack); send(8'hA5, ack);
        bus_stop();
        model[8'h35] = 8'hA5;
        tick(BUSY + 100);
        bus_start();
        send(DEV_R, ack);
        recv(1'b0, v); check("R7 current read after write", v, model[8'h36]);
        bus_stop();
        read_at(8'h35, "R6");
        recv(1'b0, v); check("R4 byte write", v, 8'hA5);
        bus_stop();

        // R4: 18 bytes from 0x2E wrap inside page 0x20, last writes win
        bus_start();
        send(DEV_W, ack); send(8'h2E, ack);
        for (int i = 0; i < 18; i++) begin
            a = {4'h2, 4'(14 + i)};
            send(8'(8'h80 + i), ack); check("R4 overflow data ack", 8'(ack), 8'd1);
            model[a] = 8'(8'h80 + i);
        end
        bus_stop();
        tick(BUSY + 100);
        read_at(8'h20, "R6");
        for (int i = 0; i < 17; i++) begin
            recv(i != 16, v);
            check("R4 page wrap content", v, model[8'(8'h20 + i)]);
        end
        bus_stop();

        // R5: repeated start before stop discards buffered data
        bus_start();
        send(DEV_W, ack); send(8'h50, ack); send(8'h11, ack);
        bus_start();
        send(DEV_R, ack); check("R5 dev ack, no busy", 8'(ack), 8'd1);
        recv(1'b0, v); check("R5 counter advanced", v, model[8'h51]);
        bus_stop();
        read_at(8'h50, "R5");
        recv(1'b0, v); check("R5 array unchanged", v, model[8'h50]);
        bus_stop();

        // R10: write protect
        wp = 1'b1;
        bus_start();
        send(DEV_W, ack); send(8'h60, ack);
        send(8'h22, ack); check("R10 data acked", 8'(ack), 8'd1);
        bus_stop();
        read_at(8'h60, "R10");
        recv(1'b0, v); check("R10 array unchanged", v, model[8'h60]);
        bus_stop();
        wp = 1'b0;

        // R11: supply lockout
        slow = 1'b1;
        bus_start();
        send(DEV_W, ack); send(8'h70, ack);
        send(8'h33, ack); check("R11 data acked", 8'(ack), 8'd1);
        bus_stop();
        read_at(8'h70, "R11");
        recv(1'b0, v); check("R11 array unchanged", v, model[8'h70]);
        bus_stop();
        slow = 1'b0;

        check("R12 sda changes only with scl low", 8'(r12_viol), 8'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule